// File: doc/BRIEF.md
# Interrupt Entry and Return Controller

This block is the interrupt-handling slice of a processor control unit. Device request lines are caught in a pending register, and that register is examined only when the control unit signals the end of an instruction cycle. If the running program has interrupts enabled and at least one request is pending, the block accepts the lowest-numbered request. It saves the current program counter and status word in private save registers and clears the accepted request bit. On the next cycle it redirects the fetch to the handler slot in the vector table: the table base plus four bytes per request number. It also loads a status word that has supervisor mode set and interrupts disabled.

While a handler runs, the block accepts no other request. Requests that arrive in that time stay latched. A return-from-interrupt, presented at an instruction boundary, makes the block reload the saved program counter and the saved status word. This restores the previous privilege mode and the previous interrupt-enable state, and any waiting request can then be taken at a later boundary. The vector table base is a register inside the block, written through a simple write strobe.

The controller is a four-state machine. ST_RUN is normal execution. ST_ENTER is the single cycle that issues the handler redirect. ST_HANDLER means a handler is in progress. ST_LEAVE is the single cycle that issues the restore. The transitions are as follows:
- take: ST_RUN to ST_ENTER, at a boundary with interrupts enabled and a request pending.
- enter_done: ST_ENTER to ST_HANDLER, unconditionally.
- rti: ST_HANDLER to ST_LEAVE, at a boundary with the return input high.
- leave_done: ST_LEAVE to ST_RUN, unconditionally.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset, pc_load_o, psw_load_o and irq_ack_o are all zero, and the controller is in normal execution with no request pending.
- R2: At a cycle where boundary_i is high, psw_i bit 1 (interrupt enable) is 1 and a request is pending, the next cycle shows pc_load_o=1 with pc_next_o equal to the vector base plus 4 times the accepted request number.
- R3: A pending request is not accepted in a cycle where boundary_i is low or where psw_i bit 1 is 0. It stays pending for a later boundary.
- R4: When several requests are pending, the lowest-numbered one is accepted. In the redirect cycle, irq_ack_o has exactly that bit set, and irq_ack_o is zero in every other cycle.
- R5: The status word loaded on entry equals psw_i as sampled at the accepting boundary, with bit 0 (supervisor) forced to 1, bit 1 (interrupt enable) forced to 0, and all other bits unchanged.
- R6: From acceptance until the return completes, no further request is accepted, even if psw_i bit 1 is 1. Requests arriving in that interval stay pending and are serviced after the return.
- R7: A cycle with boundary_i and rti_i both high during a handler causes, in the next cycle, pc_load_o=1 and psw_load_o=1, with pc_next_o and psw_next_o equal to the pc_i and psw_i sampled when the request was accepted.
- R8: rti_i has no effect outside a handler: no load is issued.
- R9: A write with ivec_we_i=1 replaces the vector base from the next cycle onward, and later handler addresses use the new base.
- R10: The accepted request bit is cleared at acceptance, so a request is serviced once per pulse and is not taken again after the return unless it is raised again.
- R11: pc_load_o and psw_load_o are always equal, and each load lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NIRQ | Request lines, OR-ed into the pending register every cycle |
| boundary_i | input | 1 | High in the cycle that ends an instruction |
| rti_i | input | 1 | Return-from-interrupt, qualified by boundary_i |
| pc_i | input | AW | Program counter of the running program |
| psw_i | input | PW | Current status word (bit 0 supervisor, bit 1 interrupt enable) |
| ivec_we_i | input | 1 | Vector base write strobe |
| ivec_wdata_i | input | AW | New vector base |
| pc_load_o | output | 1 | Load pc_next_o into the program counter |
| pc_next_o | output | AW | Redirected program counter |
| psw_load_o | output | 1 | Load psw_next_o into the status word |
| psw_next_o | output | PW | New status word |
| irq_ack_o | output | NIRQ | One-hot acknowledge of the accepted request |

## Verification
A request pulse reaches the pending register at the first rising edge. A boundary is evaluated at the edge that samples it. The redirect or restore then appears for exactly the following cycle, which is one cycle after the boundary. The bench drives every input on the falling edge. Each time it presents a boundary, it computes whether a load is due and pushes the expected address, status word and acknowledge into a queue. A monitor then compares any load against the head of that queue on the next falling edge. When the bench expects no reaction, it samples the load outputs at that same falling edge, and any load that arrives with an empty queue counts as a failure.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int SUP_BIT = 0;
    localparam int IE_BIT  = 1;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ENTER,
        ST_HANDLER,
        ST_LEAVE
    } ctrl_state_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int NIRQ = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] set_i,
    input  logic [NIRQ-1:0] clr_i,
    output logic [NIRQ-1:0] pend_o
);
    // a new request on the clearing edge wins over the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int NIRQ = 8,
    parameter int IDXW = 3
) (
    input  logic [NIRQ-1:0] req_i,
    output logic            valid_o,
    output logic [IDXW-1:0] idx_o,
    output logic [NIRQ-1:0] onehot_o
);
    for (genvar g = 0; g < NIRQ; g++) begin : g_pick
        if (g == 0) begin : g_first
            assign onehot_o[g] = req_i[g];
        end else begin : g_rest
            assign onehot_o[g] = req_i[g] & ~(|req_i[g-1:0]);
        end
    end

    assign valid_o = |req_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (onehot_o[i]) idx_o = idx_o | IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs #(
    parameter int AW   = 32,
    parameter int PW   = 8,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [PW-1:0]   psw_i,
    input  logic [IDXW-1:0] idx_i,
    output logic [AW-1:0]   pc_o,
    output logic [PW-1:0]   psw_o,
    output logic [IDXW-1:0] idx_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_o  <= '0;
            psw_o <= '0;
            idx_o <= '0;
        end else if (cap_i) begin
            pc_o  <= pc_i;
            psw_o <= psw_i;
            idx_o <= idx_i;
        end
    end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int          NIRQ     = 8,
    parameter int          AW       = 32,
    parameter int          PW       = 8,
    parameter logic [31:0] IVEC_RST = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            boundary_i,
    input  logic            rti_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [PW-1:0]   psw_i,
    input  logic            ivec_we_i,
    input  logic [AW-1:0]   ivec_wdata_i,
    output logic            pc_load_o,
    output logic [AW-1:0]   pc_next_o,
    output logic            psw_load_o,
    output logic [PW-1:0]   psw_next_o,
    output logic [NIRQ-1:0] irq_ack_o
);
    localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    ctrl_state_e     state_q, state_d;
    logic [NIRQ-1:0] pend;
    logic [NIRQ-1:0] pick_onehot;
    logic [NIRQ-1:0] clr_vec;
    logic [IDXW-1:0] pick_idx;
    logic            pick_valid;
    logic            take;
    logic            ret;
    logic [AW-1:0]   ivec_q;
    logic [AW-1:0]   ipc;
    logic [PW-1:0]   ipsw;
    logic [IDXW-1:0] idx_q;

    irq_pend_latch #(.NIRQ(NIRQ)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (irq_i),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    irq_lowest_pick #(.NIRQ(NIRQ), .IDXW(IDXW)) u_pick (
        .req_i    (pend),
        .valid_o  (pick_valid),
        .idx_o    (pick_idx),
        .onehot_o (pick_onehot)
    );

    irq_save_regs #(.AW(AW), .PW(PW), .IDXW(IDXW)) u_save (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (take),
        .pc_i  (pc_i),
        .psw_i (psw_i),
        .idx_i (pick_idx),
        .pc_o  (ipc),
        .psw_o (ipsw),
        .idx_o (idx_q)
    );

    // acceptance and return are both gated by the instruction boundary
    assign take    = (state_q == ST_RUN) && boundary_i && psw_i[IE_BIT] && pick_valid;
    assign ret     = (state_q == ST_HANDLER) && boundary_i && rti_i;
    assign clr_vec = take ? pick_onehot : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ivec_q <= IVEC_RST[AW-1:0];
        else if (ivec_we_i) ivec_q <= ivec_wdata_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions: take, enter_done, rti, leave_done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (take) state_d = ST_ENTER;
            ST_ENTER:   state_d = ST_HANDLER;
            ST_HANDLER: if (ret) state_d = ST_LEAVE;
            ST_LEAVE:   state_d = ST_RUN;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        pc_load_o  = 1'b0;
        psw_load_o = 1'b0;
        pc_next_o  = '0;
        psw_next_o = '0;
        irq_ack_o  = '0;
        unique case (state_q)
            ST_RUN, ST_HANDLER: ;
            ST_ENTER: begin
                pc_load_o  = 1'b1;
                psw_load_o = 1'b1;
                pc_next_o  = ivec_q + (AW'(idx_q) << 2);
                psw_next_o = ipsw;
                psw_next_o[SUP_BIT] = 1'b1;
                psw_next_o[IE_BIT]  = 1'b0;
                irq_ack_o  = NIRQ'(1) << idx_q;
            end
            ST_LEAVE: begin
                pc_load_o  = 1'b1;
                psw_load_o = 1'b1;
                pc_next_o  = ipc;
                psw_next_o = ipsw;
            end
        endcase
    end
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk
    import irq_entry_pkg::*;
#(
    parameter int NIRQ = 8,
    parameter int AW   = 32,
    parameter int PW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            boundary_i,
    input logic            rti_i,
    input logic [PW-1:0]   psw_i,
    input logic            pc_load_o,
    input logic            psw_load_o,
    input logic [PW-1:0]   psw_next_o,
    input logic [NIRQ-1:0] irq_ack_o
);
    a_r11_load_pair: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o == psw_load_o);

    a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !pc_load_o);

    a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack_o));

    a_r2_ack_with_load: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack_o) |-> pc_load_o);

    a_r3_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack_o) |-> $past(boundary_i && psw_i[IE_BIT]));

    a_r5_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack_o) |-> (psw_next_o[SUP_BIT] && !psw_next_o[IE_BIT]));

    a_r7_return_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !(|irq_ack_o)) |-> $past(boundary_i && rti_i));
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(.NIRQ(NIRQ), .AW(AW), .PW(PW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .rti_i      (rti_i),
    .psw_i      (psw_i),
    .pc_load_o  (pc_load_o),
    .psw_load_o (psw_load_o),
    .psw_next_o (psw_next_o),
    .irq_ack_o  (irq_ack_o)
);

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 8;
    localparam int AW   = 32;
    localparam int PW   = 8;

    typedef struct {
        logic [AW-1:0]   pc;
        logic [PW-1:0]   psw;
        logic [NIRQ-1:0] ack;
        bit              is_ret;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] irq_i = '0;
    logic            boundary_i = 1'b0;
    logic            rti_i = 1'b0;
    logic [AW-1:0]   pc_i = '0;
    logic [PW-1:0]   psw_i = '0;
    logic            ivec_we_i = 1'b0;
    logic [AW-1:0]   ivec_wdata_i = '0;
    logic            pc_load_o;
    logic [AW-1:0]   pc_next_o;
    logic            psw_load_o;
    logic [PW-1:0]   psw_next_o;
    logic [NIRQ-1:0] irq_ack_o;

    int tests = 0;
    int fails = 0;
    exp_t q[$];

    // bench model of the requirements
    logic [NIRQ-1:0] m_pend = '0;
    bit              m_hdl = 0;
    logic [AW-1:0]   m_ipc = '0;
    logic [PW-1:0]   m_ipsw = '0;
    logic [AW-1:0]   m_ivec = 32'h0000_0100;

    irq_entry_ctrl #(.NIRQ(NIRQ), .AW(AW), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .boundary_i(boundary_i),
        .rti_i(rti_i), .pc_i(pc_i), .psw_i(psw_i), .ivec_we_i(ivec_we_i),
        .ivec_wdata_i(ivec_wdata_i), .pc_load_o(pc_load_o), .pc_next_o(pc_next_o),
        .psw_load_o(psw_load_o), .psw_next_o(psw_next_o), .irq_ack_o(irq_ack_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares each load with the head of the queue
    bit prev_load = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_load && pc_load_o) chk(0, "R11 load longer than one cycle", 1, 0);
                if (pc_load_o || psw_load_o) begin
                    chk(pc_load_o == psw_load_o, "R11 load pair", {63'd0, psw_load_o}, {63'd0, pc_load_o});
                    if (q.size() == 0) begin
                        chk(0, "R3/R8 unexpected load", {32'd0, pc_next_o}, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(pc_next_o == e.pc, e.is_ret ? "R7 return pc" : "R2/R9 handler address",
                            {32'd0, pc_next_o}, {32'd0, e.pc});
                        chk(psw_next_o == e.psw, e.is_ret ? "R7 restored psw" : "R5 entry psw",
                            {56'd0, psw_next_o}, {56'd0, e.psw});
                        chk(irq_ack_o == e.ack, "R4 acknowledge", {56'd0, irq_ack_o}, {56'd0, e.ack});
                    end
                end else begin
                    if (irq_ack_o != 0) chk(0, "R4 ack without load", {56'd0, irq_ack_o}, 0);
                end
                prev_load = pc_load_o;
            end
        end
    end

    task automatic pulse_irq(input logic [NIRQ-1:0] m);
        @(negedge clk);
        irq_i = m;
        m_pend = m_pend | m;
        @(negedge clk);
        irq_i = '0;
    endtask

    task automatic set_ivec(input logic [AW-1:0] v);
        @(negedge clk);
        ivec_we_i = 1'b1;
        ivec_wdata_i = v;
        m_ivec = v;
        @(negedge clk);
        ivec_we_i = 1'b0;
    endtask

    // present one instruction boundary; req names the check when no load is due
    task automatic step(input logic [AW-1:0] pc, input logic [PW-1:0] psw, input bit rti, input string req);
        bit expect_none;
        exp_t e;
        @(negedge clk);
        boundary_i = 1'b1;
        rti_i = rti;
        pc_i = pc;
        psw_i = psw;
        expect_none = 1;
        if (!m_hdl && psw[1] && m_pend != 0) begin
            int k;
            k = 0;
            for (int i = NIRQ-1; i >= 0; i--) if (m_pend[i]) k = i;
            e.pc = m_ivec + 32'(4 * k);
            e.psw = (psw | 8'h01) & ~8'h02;
            e.ack = 8'(1) << k;
            e.is_ret = 0;
            q.push_back(e);
            m_pend[k] = 1'b0;
            m_ipc = pc;
            m_ipsw = psw;
            m_hdl = 1;
            expect_none = 0;
        end else if (m_hdl && rti) begin
            e.pc = m_ipc;
            e.psw = m_ipsw;
            e.ack = '0;
            e.is_ret = 1;
            q.push_back(e);
            m_hdl = 0;
            expect_none = 0;
        end
        @(negedge clk);
        boundary_i = 1'b0;
        rti_i = 1'b0;
        if (expect_none) chk(pc_load_o == 1'b0, req, {63'd0, pc_load_o}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pc_load_o == 0 && psw_load_o == 0, "R1 loads in reset", {63'd0, pc_load_o}, 0);
        chk(irq_ack_o == 0, "R1 ack in reset", {56'd0, irq_ack_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pc_load_o == 0 && irq_ack_o == 0, "R1 after reset", {63'd0, pc_load_o}, 0);
        step(32'h0000_0040, 8'h02, 0, "R1 nothing pending after reset");

        // R9: new vector base
        set_ivec(32'h0000_1000);

        // R3: pending but no boundary
        pulse_irq(8'b0010_0100);
        repeat (4) @(negedge clk);
        chk(pc_load_o == 0, "R3 no boundary", {63'd0, pc_load_o}, 0);

        // R2 R4 R5: bit 2 wins over bit 5
        step(32'h0000_0200, 8'hA2, 0, "R2 entry");

        // R6: new request inside handler, boundaries with enable set
        pulse_irq(8'b0000_0001);
        step(32'h0000_1008, 8'h03, 0, "R6 no entry inside handler");
        step(32'h0000_100C, 8'hA3, 0, "R6 no entry inside handler");

        // R7: return
        step(32'h0000_1010, 8'h01, 1, "R7 return");

        // R3: interrupt enable clear
        step(32'h0000_0204, 8'h00, 0, "R3 enable clear");
        step(32'h0000_0208, 8'hF1, 0, "R3 enable clear");

        // R6: latched bit 0 served after return
        step(32'h0000_020C, 8'h06, 0, "R6 latched request");
        step(32'h0000_1020, 8'h01, 1, "R7 return");
        step(32'h0000_0210, 8'h42, 0, "R4 bit 5");
        step(32'h0000_1040, 8'h01, 1, "R7 return");

        // R8: return outside handler ignored
        step(32'h0000_0214, 8'h02, 1, "R8 rti outside handler");

        // R10: serviced bits cleared
        step(32'h0000_0218, 8'h02, 0, "R10 no re-entry");

        // R9: another base
        set_ivec(32'h2000_0000);
        pulse_irq(8'b1000_0000);
        step(32'h0000_021C, 8'h82, 0, "R9 entry");
        step(32'h2000_001C, 8'h81, 1, "R7 return");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R2/R7 expected load missing", 64'(q.size()), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule